// File: doc/BRIEF.md
# Sequencing Controller for a Bus-Master Instruction Engine

This block steps through a program of fixed 32-bit instruction words. Each word names one bus operation. The block fetches the word at its program counter and decodes three fields from it: a control nibble, an 8-bit target address and an 8-bit write value. It then either runs one bus transfer or spends an equal stretch of idle states, and afterwards it advances the counter by one. A transfer follows a fixed order. The block raises a request, waits for the arbiter to grant the bus, drives the address, control and (for writes) data lines, and waits for the addressed agent to acknowledge.

A single interrupt line can end a program run. The line is looked at once at the close of every transfer and at the close of every idle stretch. If it is high at that point, the block gives a one-cycle acknowledge and then parks in a halt state. Only reset leaves the halt state. The instruction store lies outside the block: the block presents the program counter and reads back the word addressed by it, combinationally, in the same cycle.

The block has no data stream, so it has no valid/ready pair. Every pin is plain control or status. The arbiter grant and the agent acknowledge are level inputs, and they are only looked at in the state that waits for them. The address, data and control lines are shared tri-state lines, and the block releases them whenever it is not driving them.

Top module: `bus_master_seq`

## Requirements
- R1: Reset is active-low and asynchronous. While it is low, `prog_addr` is 0, `bus_req` and `irq_ack` are 0, and the address, data and control lines are released (high impedance).
- R2: Fields of `instr_word`: the write value is bits 7:0, the target address is bits 15:8 and the control nibble is bits 19:16. Bits 31:20 are ignored. Control bit 0 means read, bit 1 write, bit 2 memory space and bit 3 I/O space, so 0x5 is a memory read, 0xA an I/O write, 0x6 a memory write and 0x9 an I/O read. While the lines are driven, `bus_addr` and `bus_ctrl` carry these fields.
- R3: For a word whose control nibble is not zero, `bus_req` rises one cycle after the fetch state. It stays high, with the lines released, for as long as `bus_grant` is low.
- R4: One cycle after `bus_grant` is seen high, the lines are driven and `bus_req` stays high. Both hold until `bus_ack` is seen high. One cycle later the lines are released and `bus_req` is low.
- R5: `bus_data` is driven only while the lines are driven and control bit 1 (write) is set. On reads it stays released. `bus_addr` and `bus_ctrl` are released whenever the lines are not driven.
- R6: A word whose control nibble is 0 is a nop. It takes exactly five cycles from fetch to the next fetch, which equals a transfer whose grant and acknowledge are already high. During those cycles it raises neither `bus_req` nor the drive enable.
- R7: `irq` is sampled only in the last state of a transfer or nop. If it is high there, `irq_ack` is high for exactly one cycle and the counter does not advance. If `irq` is high at any other time and low at that point, it has no effect.
- R8: After the interrupt acknowledge, the block stays in a halt state until reset. In the halt state `bus_req`, `irq_ack` and the line drivers are off, and `prog_addr` is frozen.
- R9: Each completed instruction gives one single-cycle count step, and `prog_addr` rises by 1 at the end of that cycle. The counter wraps from 255 to 0.
- R10: State codes are assigned so that every state change flips exactly one bit of the state register. The one exception is the step from the count state back to the fetch state, which closes an odd-length loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_word | input | 32 | Instruction word stored at `prog_addr` |
| prog_addr | output | 8 | Program counter, used as the instruction store index |
| bus_grant | input | 1 | Arbiter has granted the bus |
| bus_ack | input | 1 | Addressed agent has finished the transfer |
| irq | input | 1 | Interrupt request, always enabled |
| bus_req | output | 1 | Bus request to the arbiter |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| bus_addr | inout | 8 | Shared address lines, driven or released |
| bus_data | inout | 8 | Shared data lines, driven only for writes |
| bus_ctrl | inout | 4 | Shared control lines, driven or released |

## Verification
The bench builds the block with its default widths: a 32-bit word with 8-bit address and data fields, a 4-bit control nibble and an 8-bit counter. With these widths, a run of 256 nops is short enough to carry the counter through its 255-to-0 wrap. With the 4-bit nibble, the bench can use the four transfer codes from R2 together with the all-zero nop. The bench also holds its own weak-keeper pattern on the shared lines, so a released line reads back that pattern, and a driver left on when it should be off shows up as a wrong value.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  // Codes chosen so every step but COUNT->CHECK flips one bit (R10)
  typedef enum logic [3:0] {
    ST_CHECK = 4'b0000,
    ST_REQ   = 4'b0001,
    ST_DRIVE = 4'b0011,
    ST_BEND  = 4'b0111,
    ST_COUNT = 4'b0101,
    ST_NOP1  = 4'b1000,
    ST_NOP2  = 4'b1001,
    ST_NOP3  = 4'b1101,
    ST_INTA  = 4'b1111,
    ST_STOP  = 4'b1110
  } seq_state_e;

  localparam int CB_READ  = 0;
  localparam int CB_WRITE = 1;
  localparam int CB_MEM   = 2;
  localparam int CB_IO    = 3;

endpackage

// File: rtl/bmc_decode.sv
module bmc_decode #(
  parameter int INSTR_W = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int CTRL_W  = 4
) (
  input  logic [INSTR_W-1:0] instr_word,
  output logic [ADDR_W-1:0]  addr_f,
  output logic [DATA_W-1:0]  data_f,
  output logic [CTRL_W-1:0]  ctrl_f,
  output logic               nop_flag,
  output logic               wr_flag
);
  localparam int ADDR_LO = DATA_W;
  localparam int CTRL_LO = DATA_W + ADDR_W;
  localparam int USED_W  = CTRL_LO + CTRL_W;

  assign data_f   = instr_word[DATA_W-1:0];
  assign addr_f   = instr_word[ADDR_LO +: ADDR_W];
  assign ctrl_f   = instr_word[CTRL_LO +: CTRL_W];
  assign nop_flag = (ctrl_f == '0);
  assign wr_flag  = ctrl_f[bmc_pkg::CB_WRITE];

  // Upper bits carry nothing (R2)
  generate
    if (INSTR_W > USED_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^instr_word[INSTR_W-1:USED_W];
    end
  endgenerate
endmodule

// File: rtl/bmc_pc.sv
module bmc_pc #(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            count,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] PC_ONE = 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc <= '0;
    else if (count) pc <= pc + PC_ONE;
  end

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count |=> (pc == $past(pc) + PC_ONE));
  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !count |=> $stable(pc));
endmodule

// File: rtl/bmc_fsm.sv
module bmc_fsm
  import bmc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nop_flag,
  input  logic grant,
  input  logic ack,
  input  logic irq,
  output logic bus_req,
  output logic bus_en,
  output logic count,
  output logic irq_ack,
  output logic in_check,
  output logic at_end,
  output logic stopped
);
  seq_state_e state, state_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_CHECK;
    else        state <= state_nx;
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_CHECK: state_nx = nop_flag ? ST_NOP1 : ST_REQ;
      ST_REQ:   if (grant) state_nx = ST_DRIVE;
      ST_DRIVE: if (ack)   state_nx = ST_BEND;
      ST_BEND:  state_nx = irq ? ST_INTA : ST_COUNT;
      ST_NOP1:  state_nx = ST_NOP2;
      ST_NOP2:  state_nx = ST_NOP3;
      ST_NOP3:  state_nx = irq ? ST_INTA : ST_COUNT;
      ST_COUNT: state_nx = ST_CHECK;
      ST_INTA:  state_nx = ST_STOP;
      ST_STOP:  state_nx = ST_STOP;
      default:  state_nx = ST_CHECK;
    endcase
  end

  // Moore outputs decoded from the registered state
  assign bus_req  = (state == ST_REQ) || (state == ST_DRIVE);
  assign bus_en   = (state == ST_DRIVE);
  assign count    = (state == ST_COUNT);
  assign irq_ack  = (state == ST_INTA);
  assign in_check = (state == ST_CHECK);
  assign at_end   = (state == ST_BEND) || (state == ST_NOP3);
  assign stopped  = (state == ST_STOP);

  // R3
  req_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_en && !grant) |=> (bus_req && !bus_en));
  // R4
  grant_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_en && grant) |=> (bus_req && bus_en));
  // R4
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !ack) |=> (bus_req && bus_en));
  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && ack) |=> (!bus_req && !bus_en));
  // R7
  irq_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && irq) |=> (irq_ack && !count));
  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!irq_ack && stopped));
  // R8
  halt_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> (stopped && !bus_req && !irq_ack && !count));
  // R9
  count_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count |=> (!count && in_check));
  // R10
  one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != $past(state)) && ($past(state) != ST_COUNT))
      |-> ($countones(state ^ $past(state)) == 1));
endmodule

// File: rtl/bmc_drive.sv
module bmc_drive #(
  parameter int CTRL_W = 4
) (
  input  logic              bus_en,
  input  logic [CTRL_W-1:0] ctrl_f,
  output logic              addr_oe,
  output logic              ctrl_oe,
  output logic              data_oe
);
  assign addr_oe = bus_en;
  assign ctrl_oe = bus_en;
  assign data_oe = bus_en && ctrl_f[bmc_pkg::CB_WRITE];

  // R5
  data_gate_chk: assert final (!data_oe || (addr_oe && ctrl_oe && ctrl_f[bmc_pkg::CB_WRITE]));
endmodule

// File: rtl/bus_master_seq.sv
module bus_master_seq #(
  parameter int INSTR_W = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int CTRL_W  = 4,
  parameter int PC_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr_word,
  output logic [PC_W-1:0]    prog_addr,
  input  logic               bus_grant,
  input  logic               bus_ack,
  input  logic               irq,
  output logic               bus_req,
  output logic               irq_ack,
  inout  wire  [ADDR_W-1:0]  bus_addr,
  inout  wire  [DATA_W-1:0]  bus_data,
  inout  wire  [CTRL_W-1:0]  bus_ctrl
);
  logic [ADDR_W-1:0] addr_f;
  logic [DATA_W-1:0] data_f;
  logic [CTRL_W-1:0] ctrl_f;
  logic nop_flag, wr_flag;
  logic bus_en, count, in_check, at_end, stopped;
  logic addr_oe, ctrl_oe, data_oe;

  bmc_decode #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_dec (
    .instr_word(instr_word), .addr_f(addr_f), .data_f(data_f),
    .ctrl_f(ctrl_f), .nop_flag(nop_flag), .wr_flag(wr_flag)
  );

  bmc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .nop_flag(nop_flag), .grant(bus_grant),
    .ack(bus_ack), .irq(irq), .bus_req(bus_req), .bus_en(bus_en),
    .count(count), .irq_ack(irq_ack), .in_check(in_check),
    .at_end(at_end), .stopped(stopped)
  );

  bmc_pc #(.PC_W(PC_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .count(count), .pc(prog_addr)
  );

  bmc_drive #(.CTRL_W(CTRL_W)) u_drv (
    .bus_en(bus_en), .ctrl_f(ctrl_f),
    .addr_oe(addr_oe), .ctrl_oe(ctrl_oe), .data_oe(data_oe)
  );

  assign bus_addr = addr_oe ? addr_f : {ADDR_W{1'bz}};
  assign bus_ctrl = ctrl_oe ? ctrl_f : {CTRL_W{1'bz}};
  assign bus_data = data_oe ? data_f : {DATA_W{1'bz}};

  // R6
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_check && nop_flag) |=> !bus_req ##1 !bus_req ##1 !bus_req ##1 (count || irq_ack));
  // R5
  write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe) |-> (wr_flag && bus_req));
  // R8
  halt_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> ($stable(prog_addr) && !addr_oe && !data_oe));
endmodule

// File: tb/bus_master_seq_test.sv
module bus_master_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_grant = 1'b0, bus_ack = 1'b0, irq = 1'b0;
  logic bus_req, irq_ack;
  logic [7:0] prog_addr;
  logic [31:0] instr_word;
  wire  [7:0] bus_addr;
  wire  [7:0] bus_data;
  wire  [3:0] bus_ctrl;
  logic kp_a = 1'b0, kp_d = 1'b0, kp_c = 1'b0;
  logic [31:0] rom [256];
  int n_chk = 0, n_bad = 0;

  localparam logic [7:0] KA = 8'hC3;
  localparam logic [7:0] KD = 8'h3C;
  localparam logic [3:0] KC = 4'h9;

  always #4 clk = ~clk;

  // keeper pattern on the shared lines; a released line reads it back
  assign bus_addr = kp_a ? KA : 8'hzz;
  assign bus_data = kp_d ? KD : 8'hzz;
  assign bus_ctrl = kp_c ? KC : 4'hz;
  assign instr_word = rom[prog_addr];

  bus_master_seq uut (
    .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .prog_addr(prog_addr),
    .bus_grant(bus_grant), .bus_ack(bus_ack), .irq(irq),
    .bus_req(bus_req), .irq_ack(irq_ack),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctrl(bus_ctrl)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic released(input string tag);
    kp_a = 1'b1; kp_d = 1'b1; kp_c = 1'b1;
    #1;
    chk(bus_addr == KA, {tag, " addr released"}, bus_addr, KA);
    chk(bus_data == KD, {tag, " data released"}, bus_data, KD);
    chk(bus_ctrl == KC, {tag, " ctrl released"}, bus_ctrl, KC);
    kp_a = 1'b0; kp_d = 1'b0; kp_c = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    #1 rst_n = 1'b0;
    bus_grant = 1'b0; bus_ack = 1'b0; irq = 1'b0;
    #1;
    chk(prog_addr == 8'h00, "R1 pc async clear", prog_addr, 0);
    chk(bus_req == 1'b0, "R1 req low", bus_req, 0);
    chk(irq_ack == 1'b0, "R1 ack low", irq_ack, 0);
    released("R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // starts and ends (unless halted) at a negedge in the fetch state
  task automatic bus_op(input logic [7:0] p, input logic [3:0] c, input logic [7:0] a,
                        input logic [7:0] d, input int gd, input int ad,
                        input bit irq_mid, input bit irq_end);
    int cyc;
    bit wr;
    wr = c[1];
    chk(prog_addr == p, "R9 pc before op", prog_addr, p);
    cyc = 0;
    tick; cyc++;
    irq = irq_mid;
    chk(bus_req == 1'b1, "R3 request raised", bus_req, 1);
    kp_a = 1'b1; kp_c = 1'b1; #1;
    chk(bus_addr == KA, "R5 addr released while waiting", bus_addr, KA);
    kp_a = 1'b0; kp_c = 1'b0;
    for (int i = 0; i < gd; i++) begin
      tick; cyc++;
      chk(bus_req == 1'b1, "R3 request held without grant", bus_req, 1);
    end
    bus_grant = 1'b1;
    tick; cyc++;
    bus_grant = 1'b0;
    if (!wr) kp_d = 1'b1;
    #1;
    chk(bus_req == 1'b1, "R4 request held while driving", bus_req, 1);
    chk(bus_addr == a, "R2 address field", bus_addr, a);
    chk(bus_ctrl == c, "R2 control field", bus_ctrl, c);
    if (wr) chk(bus_data == d, "R5 write data driven", bus_data, d);
    else    chk(bus_data == KD, "R5 read data released", bus_data, KD);
    for (int i = 0; i < ad; i++) begin
      tick; cyc++;
      chk(bus_addr == a && bus_req, "R4 drive held without ack", bus_addr, a);
    end
    kp_d = 1'b0;
    bus_ack = 1'b1;
    tick; cyc++;
    bus_ack = 1'b0;
    irq = irq_end;
    chk(bus_req == 1'b0, "R4 request dropped after ack", bus_req, 0);
    released("R4");
    tick; cyc++;
    irq = 1'b0;
    if (irq_end) begin
      chk(irq_ack == 1'b1, "R7 interrupt acknowledged", irq_ack, 1);
      chk(prog_addr == p, "R7 pc not advanced", prog_addr, p);
    end else begin
      chk(irq_ack == 1'b0, "R7 no acknowledge", irq_ack, 0);
      tick; cyc++;
      chk(prog_addr == p + 8'd1, "R9 pc advanced", prog_addr, p + 8'd1);
      if (gd == 0 && ad == 0)
        chk(cyc == 5, "R6 bus cycle length", cyc, 5);
    end
  endtask

  task automatic nop_op(input logic [7:0] p, input bit irq_end);
    int cyc;
    cyc = 0;
    tick; cyc++;
    chk(bus_req == 1'b0, "R6 nop no request", bus_req, 0);
    released("R6");
    tick; cyc++;
    chk(bus_req == 1'b0, "R6 nop no request", bus_req, 0);
    tick; cyc++;
    irq = irq_end;
    chk(bus_req == 1'b0, "R6 R10 nop no request", bus_req, 0);
    tick; cyc++;
    irq = 1'b0;
    if (irq_end) begin
      chk(irq_ack == 1'b1, "R7 interrupt after nop", irq_ack, 1);
    end else begin
      tick; cyc++;
      chk(prog_addr == p + 8'd1, "R9 pc after nop", prog_addr, p + 8'd1);
      chk(cyc == 5, "R6 nop length equals bus cycle", cyc, 5);
    end
  endtask

  task automatic halt_check(input logic [7:0] p);
    tick;
    chk(irq_ack == 1'b0, "R7 acknowledge is one cycle", irq_ack, 0);
    bus_grant = 1'b1; bus_ack = 1'b1;
    for (int i = 0; i < 12; i++) begin
      tick;
      chk(!bus_req && !irq_ack, "R8 halt quiet", {bus_req, irq_ack}, 0);
      chk(prog_addr == p, "R8 pc frozen", prog_addr, p);
    end
    released("R8");
    bus_grant = 1'b0; bus_ack = 1'b0;
  endtask

  task automatic scenario_program;
    for (int i = 0; i < 256; i++) rom[i] = 32'h0;
    rom[0] = {12'hFA5, 4'h5, 8'hF4, 8'h00};  // memory read, junk upper bits (R2)
    rom[1] = {12'h000, 4'hA, 8'h0A, 8'h55};  // I/O write
    rom[2] = 32'h0;                          // nop
    rom[3] = {12'h000, 4'h6, 8'h80, 8'hC7};  // memory write, irq mid-cycle only
    rom[4] = 32'h0;                          // nop ending in interrupt
    do_reset;
    bus_op(8'd0, 4'h5, 8'hF4, 8'h00, 2, 3, 1'b0, 1'b0);
    bus_op(8'd1, 4'hA, 8'h0A, 8'h55, 0, 0, 1'b0, 1'b0);
    nop_op(8'd2, 1'b0);
    bus_op(8'd3, 4'h6, 8'h80, 8'hC7, 1, 1, 1'b1, 1'b0);
    nop_op(8'd4, 1'b1);
    halt_check(8'd4);
  endtask

  task automatic scenario_irq_on_transfer;
    for (int i = 0; i < 256; i++) rom[i] = 32'h0;
    rom[0] = {12'h000, 4'h9, 8'h12, 8'hEE};  // I/O read
    do_reset;
    bus_op(8'd0, 4'h9, 8'h12, 8'hEE, 0, 2, 1'b0, 1'b1);
    halt_check(8'd0);
  endtask

  task automatic scenario_wrap;
    for (int i = 0; i < 256; i++) rom[i] = 32'h0;
    do_reset;
    repeat (255 * 5) tick;
    chk(prog_addr == 8'd255, "R9 pc reaches top", prog_addr, 255);
    repeat (5) tick;
    chk(prog_addr == 8'd0, "R9 pc wraps to zero", prog_addr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    scenario_program;
    scenario_irq_on_transfer;
    scenario_wrap;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule